// File: doc/BRIEF.md
# Configuration Memory Scrubber

This block keeps a configuration memory in step with a golden image. It walks the configuration memory one frame at a time. For each word it issues a read to the configuration memory and a read of the same address to the golden store in the same cycle. It then compares the two words. A word whose bits differ is a fault event. The block logs the frame index, the word offset and the XOR of the two words into a small FIFO. Every differing bit is added to a saturating counter.

Once a frame scan has found any difference, the frame is the unit of repair. The block copies the whole frame back from the golden store. It then reads the frame a second time to verify the repair. A difference that survives the rewrite raises a sticky flag for a persistent fault.

When the last frame of a pass is finished, the block emits a one-cycle done pulse. It then waits a programmable number of cycles before the next pass begins. Software sets that gap so that full passes run at least three times as often as upsets are expected. Scrubbing continues pass after pass while the enable input is high. When the enable is low, the block finishes the pass it is in and goes quiet.

Top module: `cfg_scrub_ctrl`

## Requirements
- R1: While reset is high and after it is released with `scrub_en` low, no memory strobe is active, `log_valid`, `log_overflow`, `persist_fault` and `pass_done` are 0, and `bit_err_count` is 0.
- R2: A pass reads every word, frame 0 first, offsets ascending, at linear address frame*WORDS+offset, with `gold_rd` and `gold_addr` matching `cm_rd` and `cm_addr` on every read; with no differences, `pass_done` pulses for one cycle exactly FRAMES*(WORDS+1) cycles after the first read strobe of the pass.
- R3: Each differing word read in a scan pushes one log entry holding frame, offset and XOR, in scan order; the FIFO head holds steady until `log_ready` is seen with `log_valid`.
- R4: `bit_err_count` adds the number of set bits in each logged XOR and saturates at 2^CNT_W-1.
- R5: A frame with at least one difference is rewritten in full from the golden store (WORDS write strobes, never together with a read strobe), so that the configuration memory equals the golden image afterwards; such a frame adds 2*(WORDS+1) cycles to the pass.
- R6: After a rewrite the frame is read once more. A difference on that read sets `persist_fault`, which stays set until reset. The verify read neither logs nor counts.
- R7: When the log FIFO already holds LOG_DEPTH entries, a new entry is dropped, earlier entries are kept, and `log_overflow` becomes 1 and stays 1 until reset.
- R8: With `scrub_en` high, the first read of the next pass comes `gap_cycles`+1 cycles after the `pass_done` pulse; if `scrub_en` is low when that gap ends, no further read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scrub_en | input | 1 | Keep scrubbing while high |
| gap_cycles | input | PER_W | Idle cycles between passes, minus one |
| cm_rd | output | 1 | Configuration memory read strobe (data next cycle) |
| cm_wr | output | 1 | Configuration memory write strobe |
| cm_addr | output | ADDR_W | Configuration memory word address |
| cm_wdata | output | DATA_W | Word written back during repair |
| cm_rdata | input | DATA_W | Readback word, one cycle after `cm_rd` |
| gold_rd | output | 1 | Golden store read strobe (data next cycle) |
| gold_addr | output | ADDR_W | Golden store word address |
| gold_rdata | input | DATA_W | Golden word, one cycle after `gold_rd` |
| log_valid | output | 1 | Log FIFO holds an entry |
| log_ready | input | 1 | Consumer takes the head entry |
| log_frame | output | FRM_W | Frame index of the head entry |
| log_offset | output | OFF_W | Word offset of the head entry |
| log_xor | output | DATA_W | Golden XOR readback of the head entry |
| log_overflow | output | 1 | Sticky: an entry was dropped |
| bit_err_count | output | CNT_W | Saturating count of differing bits |
| pass_done | output | 1 | One-cycle pulse at the end of each pass |
| persist_fault | output | 1 | Sticky: a rewritten frame still differed |

## Verification
The persistent-fault path is the hardest case to reach from the ports. It needs a configuration word that refuses the value written back into it. The bench's memory model therefore carries a stuck-bit mask at one address, which it ORs into every write there. The bench seeds that word with the wrong value, and the verify read after the rewrite still sees it. Log overflow and counter saturation also need lots of errors from one pass. The bench builds the block with a four-entry log and a six-bit counter, then corrupts six single bits, and later four whole words.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    // Controller phases; the ordering has no meaning outside the controller.
    typedef enum logic [2:0] {
        SC_IDLE,
        SC_READ,
        SC_COMPARE,
        SC_REWRITE,
        SC_WAIT
    } scan_state_e;

    // Index width for a count of n items, never below one bit.
    function automatic int width_of(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/scrub_cmp.sv
module scrub_cmp #(
    parameter int DATA_W = 32,
    parameter int POP_W  = 6
) (
    input  logic              valid,
    input  logic [DATA_W-1:0] seen,
    input  logic [DATA_W-1:0] ref_word,
    output logic [DATA_W-1:0] diff,
    output logic              mism,
    output logic [POP_W-1:0]  ones
);

    always_comb begin
        diff = valid ? (seen ^ ref_word) : '0;
        mism = |diff;
        ones = '0;
        for (int i = 0; i < DATA_W; i++) begin
            ones = ones + POP_W'(diff[i]);
        end
    end

endmodule

// File: rtl/scrub_sat_cnt.sv
module scrub_sat_cnt #(
    parameter int CNT_W = 32,
    parameter int INC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);

    localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
    localparam logic [SUM_W-1:0] TOP = SUM_W'({CNT_W{1'b1}});

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(cnt) + SUM_W'(inc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc_en) begin
            cnt <= (sum > TOP) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/scrub_log_fifo.sv
module scrub_log_fifo
    import scrub_pkg::*;
#(
    parameter int ENT_W = 16,
    parameter int DEPTH = 8,
    localparam int PTR_W = width_of(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [ENT_W-1:0] push_data,
    input  logic             pop,
    output logic             valid,
    output logic [ENT_W-1:0] head,
    output logic             overflow
);

    logic [ENT_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [PTR_W:0]   fill_q;
    logic             full, do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        full    = (fill_q == (PTR_W + 1)'(DEPTH));
        valid   = (fill_q != '0);
        do_push = push && !full;
        do_pop  = pop && valid;
        head    = slot_q[rd_q];
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            slot_q[wr_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q     <= '0;
            wr_q     <= '0;
            fill_q   <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wr_q <= step(wr_q);
            if (do_pop)  rd_q <= step(rd_q);
            case ({do_push, do_pop})
                2'b10:   fill_q <= fill_q + (PTR_W + 1)'(1);
                2'b01:   fill_q <= fill_q - (PTR_W + 1)'(1);
                default: fill_q <= fill_q;
            endcase
            if (push && full) overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/cfg_scrub_ctrl.sv
module cfg_scrub_ctrl
    import scrub_pkg::*;
#(
    parameter int FRAMES    = 16,
    parameter int WORDS     = 8,
    parameter int DATA_W    = 32,
    parameter int LOG_DEPTH = 8,
    parameter int CNT_W     = 32,
    parameter int PER_W     = 16,
    localparam int TOTAL    = FRAMES * WORDS,
    localparam int ADDR_W   = width_of(TOTAL),
    localparam int FRM_W    = width_of(FRAMES),
    localparam int OFF_W    = width_of(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scrub_en,
    input  logic [PER_W-1:0]  gap_cycles,
    output logic              cm_rd,
    output logic              cm_wr,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [DATA_W-1:0] cm_wdata,
    input  logic [DATA_W-1:0] cm_rdata,
    output logic              gold_rd,
    output logic [ADDR_W-1:0] gold_addr,
    input  logic [DATA_W-1:0] gold_rdata,
    output logic              log_valid,
    input  logic              log_ready,
    output logic [FRM_W-1:0]  log_frame,
    output logic [OFF_W-1:0]  log_offset,
    output logic [DATA_W-1:0] log_xor,
    output logic              log_overflow,
    output logic [CNT_W-1:0]  bit_err_count,
    output logic              pass_done,
    output logic              persist_fault
);

    localparam int IDX_W = OFF_W + 1;
    localparam int POP_W = width_of(DATA_W + 1);
    localparam int ENT_W = FRM_W + OFF_W + DATA_W;

    scan_state_e       state_q;
    logic [FRM_W-1:0]  frame_q;
    logic [IDX_W-1:0]  idx_q;
    logic              rd_vld_q;
    logic [OFF_W-1:0]  cmp_off_q;
    logic              bad_q;
    logic              verify_q;
    logic              done_q;
    logic              persist_q;
    logic [PER_W-1:0]  wait_q;

    logic [DATA_W-1:0] diff;
    logic              mism;
    logic [POP_W-1:0]  ones;
    logic              last_word, last_frame, wr_end, frame_bad, log_push;
    logic [OFF_W-1:0]  wr_off;
    logic [ENT_W-1:0]  head;

    function automatic logic [ADDR_W-1:0] to_addr(input logic [FRM_W-1:0] f,
                                                  input logic [OFF_W-1:0] o);
        return ADDR_W'(f) * ADDR_W'(WORDS) + ADDR_W'(o);
    endfunction

    // Position decode
    always_comb begin
        last_word  = (idx_q == IDX_W'(WORDS - 1));
        wr_end     = (idx_q == IDX_W'(WORDS));
        last_frame = (frame_q == FRM_W'(FRAMES - 1));
        wr_off     = OFF_W'(idx_q - IDX_W'(1));
    end

    // Memory ports: reads lead, rewrite trails the golden read by one cycle
    always_comb begin
        cm_rd     = (state_q == SC_READ);
        cm_wr     = (state_q == SC_REWRITE) && (idx_q != '0);
        gold_rd   = cm_rd || ((state_q == SC_REWRITE) && !wr_end);
        gold_addr = to_addr(frame_q, idx_q[OFF_W-1:0]);
        cm_addr   = cm_rd ? gold_addr : to_addr(frame_q, wr_off);
        cm_wdata  = gold_rdata;
    end

    scrub_cmp #(
        .DATA_W (DATA_W),
        .POP_W  (POP_W)
    ) u_cmp (
        .valid    (rd_vld_q),
        .seen     (cm_rdata),
        .ref_word (gold_rdata),
        .diff     (diff),
        .mism     (mism),
        .ones     (ones)
    );

    always_comb begin
        log_push  = mism && !verify_q;
        frame_bad = bad_q || mism;
    end

    scrub_log_fifo #(
        .ENT_W (ENT_W),
        .DEPTH (LOG_DEPTH)
    ) u_log (
        .clk       (clk),
        .rst       (rst),
        .push      (log_push),
        .push_data ({frame_q, cmp_off_q, diff}),
        .pop       (log_ready),
        .valid     (log_valid),
        .head      (head),
        .overflow  (log_overflow)
    );

    always_comb begin
        log_frame  = head[ENT_W-1 -: FRM_W];
        log_offset = head[DATA_W +: OFF_W];
        log_xor    = head[DATA_W-1:0];
    end

    scrub_sat_cnt #(
        .CNT_W (CNT_W),
        .INC_W (POP_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .inc_en (log_push),
        .inc    (ones),
        .cnt    (bit_err_count)
    );

    // Read-data alignment
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld_q  <= 1'b0;
            cmp_off_q <= '0;
        end else begin
            rd_vld_q  <= cm_rd;
            cmp_off_q <= idx_q[OFF_W-1:0];
        end
    end

    // Sticky persistent-fault flag, set only by the verify read
    always_ff @(posedge clk) begin
        if (rst) persist_q <= 1'b0;
        else if (mism && verify_q) persist_q <= 1'b1;
    end

    // Scan sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SC_IDLE;
            frame_q  <= '0;
            idx_q    <= '0;
            bad_q    <= 1'b0;
            verify_q <= 1'b0;
            done_q   <= 1'b0;
            wait_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SC_IDLE: begin
                    if (scrub_en) begin
                        state_q  <= SC_READ;
                        frame_q  <= '0;
                        idx_q    <= '0;
                        bad_q    <= 1'b0;
                        verify_q <= 1'b0;
                    end
                end
                SC_READ: begin
                    bad_q <= frame_bad;
                    idx_q <= idx_q + IDX_W'(1);
                    if (last_word) state_q <= SC_COMPARE;
                end
                SC_COMPARE: begin
                    bad_q <= 1'b0;
                    idx_q <= '0;
                    if (frame_bad && !verify_q) begin
                        state_q <= SC_REWRITE;
                    end else begin
                        verify_q <= 1'b0;
                        if (last_frame) begin
                            state_q <= SC_WAIT;
                            wait_q  <= gap_cycles;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= SC_READ;
                            frame_q <= frame_q + FRM_W'(1);
                        end
                    end
                end
                SC_REWRITE: begin
                    if (wr_end) begin
                        state_q  <= SC_READ;
                        idx_q    <= '0;
                        verify_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                SC_WAIT: begin
                    if (wait_q == '0) begin
                        frame_q <= '0;
                        idx_q   <= '0;
                        state_q <= scrub_en ? SC_READ : SC_IDLE;
                    end else begin
                        wait_q <= wait_q - PER_W'(1);
                    end
                end
                default: state_q <= SC_IDLE;
            endcase
        end
    end

    always_comb begin
        pass_done     = done_q;
        persist_fault = persist_q;
    end

endmodule

// File: rtl/scrub_chk.sv
module scrub_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cm_rd,
    input logic              cm_wr,
    input logic [ADDR_W-1:0] cm_addr,
    input logic              gold_rd,
    input logic [ADDR_W-1:0] gold_addr,
    input logic              log_valid,
    input logic              log_ready,
    input logic [DATA_W-1:0] log_xor,
    input logic              log_overflow,
    input logic [CNT_W-1:0]  bit_err_count,
    input logic              pass_done,
    input logic              persist_fault
);

    AST_READ_PAIRED: assert property (@(posedge clk) disable iff (rst)
        cm_rd |-> (gold_rd && gold_addr == cm_addr)); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pass_done |=> !pass_done); // R2

    AST_LOG_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
        (log_valid && !log_ready) |=> (log_valid && $stable(log_xor))); // R3

    AST_COUNT_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bit_err_count >= $past(bit_err_count))); // R4

    AST_NO_RD_WR_MIX: assert property (@(posedge clk) disable iff (rst)
        !(cm_rd && cm_wr)); // R5

    AST_PERSIST_HELD: assert property (@(posedge clk) disable iff (rst)
        persist_fault |=> persist_fault); // R6

    AST_OVERFLOW_HELD: assert property (@(posedge clk) disable iff (rst)
        log_overflow |=> log_overflow); // R7

endmodule

bind cfg_scrub_ctrl scrub_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_scrub_chk (
    .clk           (clk),
    .rst           (rst),
    .cm_rd         (cm_rd),
    .cm_wr         (cm_wr),
    .cm_addr       (cm_addr),
    .gold_rd       (gold_rd),
    .gold_addr     (gold_addr),
    .log_valid     (log_valid),
    .log_ready     (log_ready),
    .log_xor       (log_xor),
    .log_overflow  (log_overflow),
    .bit_err_count (bit_err_count),
    .pass_done     (pass_done),
    .persist_fault (persist_fault)
);

// File: tb/test_cfg_scrub_ctrl.sv
module test_cfg_scrub_ctrl;

    localparam int F   = 4;
    localparam int W   = 4;
    localparam int DW  = 16;
    localparam int LD  = 4;
    localparam int CW  = 6;
    localparam int PW  = 8;
    localparam int TOT = F * W;
    localparam int AW  = 4;
    localparam int FW  = 2;
    localparam int OW  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          scrub_en = 1'b0;
    logic [PW-1:0] gap_cycles = '0;
    logic          cm_rd, cm_wr, gold_rd;
    logic [AW-1:0] cm_addr, gold_addr;
    logic [DW-1:0] cm_wdata;
    logic [DW-1:0] cm_rdata = '0;
    logic [DW-1:0] gold_rdata = '0;
    logic          log_valid, log_overflow, pass_done, persist_fault;
    logic          log_ready = 1'b0;
    logic [FW-1:0] log_frame;
    logic [OW-1:0] log_offset;
    logic [DW-1:0] log_xor;
    logic [CW-1:0] bit_err_count;

    cfg_scrub_ctrl #(
        .FRAMES (F), .WORDS (W), .DATA_W (DW),
        .LOG_DEPTH (LD), .CNT_W (CW), .PER_W (PW)
    ) i_cfg_scrub_ctrl (
        .clk (clk), .rst (rst), .scrub_en (scrub_en), .gap_cycles (gap_cycles),
        .cm_rd (cm_rd), .cm_wr (cm_wr), .cm_addr (cm_addr), .cm_wdata (cm_wdata),
        .cm_rdata (cm_rdata), .gold_rd (gold_rd), .gold_addr (gold_addr),
        .gold_rdata (gold_rdata), .log_valid (log_valid), .log_ready (log_ready),
        .log_frame (log_frame), .log_offset (log_offset), .log_xor (log_xor),
        .log_overflow (log_overflow), .bit_err_count (bit_err_count),
        .pass_done (pass_done), .persist_fault (persist_fault)
    );

    // Golden image, bit 4 always clear so a stuck-at-1 there is a real fault
    function automatic logic [DW-1:0] gold_val(input int i);
        return DW'(i * 11335 + 20899) & 16'hffef;
    endfunction

    // Configuration memory model with an optional stuck bit
    logic [DW-1:0] cfg_mem [TOT];
    logic [AW-1:0] stuck_addr = '0;
    logic [DW-1:0] stuck_mask = '0;
    logic          poke_en = 1'b0;
    logic [AW-1:0] poke_addr = '0;
    logic [DW-1:0] poke_val = '0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TOT; i++) cfg_mem[i] <= gold_val(i);
        end else begin
            if (cm_wr) cfg_mem[cm_addr] <= cm_wdata | ((cm_addr == stuck_addr) ? stuck_mask : '0);
            if (poke_en) cfg_mem[poke_addr] <= poke_val;
        end
        if (cm_rd) cm_rdata <= cfg_mem[cm_addr];
        if (gold_rd) gold_rdata <= gold_val(int'(gold_addr));
    end

    // Port monitor, sampled mid-cycle
    int cyc = 0;
    int rd_n = 0;
    int wr_n = 0;
    int done_n = 0;
    int done_cyc = 0;
    int rd_cyc [512];
    int rd_adr [512];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cm_rd) begin
            if (rd_n < 512) begin
                rd_cyc[rd_n] = cyc;
                rd_adr[rd_n] = int'(cm_addr);
            end
            rd_n = rd_n + 1;
        end
        if (cm_wr) wr_n = wr_n + 1;
        if (pass_done) begin
            done_n   = done_n + 1;
            done_cyc = cyc;
        end
    end

    int total = 0;
    int bad = 0;
    int last_len = 0;
    int last_wr = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [DW-1:0] v);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = AW'(a); poke_val = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic corrupt(input int f, input int o, input logic [DW-1:0] x);
        poke(f * W + o, gold_val(f * W + o) ^ x);
    endtask

    task automatic run_pass(input int gap);
        int d0, r0, w0, d;
        d0 = done_n; r0 = rd_n; w0 = wr_n;
        @(negedge clk);
        gap_cycles = PW'(gap);
        scrub_en = 1'b1;
        wait (done_n == d0 + 1);
        d = done_cyc;
        @(negedge clk);
        scrub_en = 1'b0;
        repeat (gap + 3) @(negedge clk);
        last_len = d - rd_cyc[r0];
        last_wr  = wr_n - w0;
    endtask

    task automatic pop_expect(input int f, input int o, input int x, input string tag);
        @(negedge clk);
        chk(log_valid == 1'b1, {tag, " log entry present"}, int'(log_valid), 1);
        chk(int'(log_frame) == f && int'(log_offset) == o && int'(log_xor) == x,
            {tag, " log entry {frame,offset,xor}"},
            (int'(log_frame) << 24) | (int'(log_offset) << 16) | int'(log_xor),
            (f << 24) | (o << 16) | x);
        log_ready = 1'b1;
        @(negedge clk);
        log_ready = 1'b0;
    endtask

    task automatic mem_matches(input string tag);
        int n;
        n = 0;
        for (int i = 0; i < TOT; i++) if (cfg_mem[i] !== gold_val(i)) n = n + 1;
        chk(n == 0, {tag, " configuration equals golden image"}, n, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!cm_rd && !cm_wr && !gold_rd, "R1 no strobes in reset", int'({cm_rd, cm_wr, gold_rd}), 0);
        chk(!log_valid && !log_overflow && !persist_fault && !pass_done, "R1 flags clear in reset",
            int'({log_valid, log_overflow, persist_fault, pass_done}), 0);
        chk(bit_err_count == '0, "R1 counter zero", int'(bit_err_count), 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk(rd_n == 0 && wr_n == 0, "R1 idle with scrub_en low", rd_n + wr_n, 0);
    endtask

    task automatic t_clean_pass();
        int r0, errs;
        r0 = rd_n;
        run_pass(2);
        chk(last_len == F * (W + 1), "R2 clean pass length", last_len, F * (W + 1));
        errs = 0;
        for (int k = 0; k < TOT; k++) if (rd_adr[r0 + k] != k) errs = errs + 1;
        chk(errs == 0 && rd_n - r0 == TOT, "R2 scan address order", rd_n - r0, TOT);
        chk(log_valid == 1'b0 && last_wr == 0, "R3 clean pass logs and writes nothing",
            int'(log_valid) + last_wr, 0);
    endtask

    task automatic t_single_error();
        corrupt(2, 1, 16'h0104);
        run_pass(2);
        chk(bit_err_count == CW'(2), "R4 two bits counted", int'(bit_err_count), 2);
        chk(last_wr == W, "R5 frame rewritten in full", last_wr, W);
        chk(last_len == F * (W + 1) + 2 * (W + 1), "R5 repair pass length", last_len, F * (W + 1) + 2 * (W + 1));
        mem_matches("R5 single");
        chk(persist_fault == 1'b0, "R6 no persistent fault after good repair", int'(persist_fault), 0);
        pop_expect(2, 1, 16'h0104, "R3 single");
        @(negedge clk);
        chk(log_valid == 1'b0, "R3 one entry only", int'(log_valid), 0);
    endtask

    task automatic t_multi_error();
        corrupt(0, 3, 16'h8000);
        corrupt(3, 0, 16'h00ff);
        corrupt(0, 0, 16'h0001);
        run_pass(2);
        chk(bit_err_count == CW'(12), "R4 accumulated bits", int'(bit_err_count), 12);
        chk(last_wr == 2 * W, "R5 two frames rewritten", last_wr, 2 * W);
        mem_matches("R5 multi");
        pop_expect(0, 0, 16'h0001, "R3 order first");
        pop_expect(0, 3, 16'h8000, "R3 order second");
        pop_expect(3, 0, 16'h00ff, "R3 order third");
    endtask

    task automatic t_persistent();
        @(negedge clk);
        stuck_addr = AW'(1 * W + 2);
        stuck_mask = 16'h0010;
        corrupt(1, 2, 16'h0010);
        run_pass(2);
        chk(persist_fault == 1'b1, "R6 stuck bit flagged", int'(persist_fault), 1);
        chk(bit_err_count == CW'(13), "R6 verify read not counted", int'(bit_err_count), 13);
        pop_expect(1, 2, 16'h0010, "R6 scan entry");
        @(negedge clk);
        chk(log_valid == 1'b0, "R6 verify read not logged", int'(log_valid), 0);
        stuck_mask = '0;
        run_pass(2);
        mem_matches("R6 after stuck cleared");
        chk(persist_fault == 1'b1, "R6 flag sticky", int'(persist_fault), 1);
        pop_expect(1, 2, 16'h0010, "R6 rescan entry");
    endtask

    task automatic t_overflow();
        corrupt(0, 1, 16'h0001);
        corrupt(1, 0, 16'h0002);
        corrupt(1, 3, 16'h0004);
        corrupt(2, 2, 16'h0008);
        corrupt(3, 1, 16'h0020);
        corrupt(3, 3, 16'h0040);
        run_pass(2);
        chk(log_overflow == 1'b1, "R7 overflow raised", int'(log_overflow), 1);
        chk(bit_err_count == CW'(20), "R7 dropped entries still counted", int'(bit_err_count), 20);
        mem_matches("R7");
        pop_expect(0, 1, 16'h0001, "R7 kept 1");
        pop_expect(1, 0, 16'h0002, "R7 kept 2");
        pop_expect(1, 3, 16'h0004, "R7 kept 3");
        pop_expect(2, 2, 16'h0008, "R7 kept 4");
        @(negedge clk);
        chk(log_valid == 1'b0 && log_overflow == 1'b1, "R7 later entries dropped, flag held",
            int'({log_valid, log_overflow}), 1);
    endtask

    task automatic t_saturate();
        for (int o = 0; o < W; o++) corrupt(0, o, 16'hffff);
        run_pass(2);
        chk(bit_err_count == CW'(63), "R4 counter saturates", int'(bit_err_count), 63);
        mem_matches("R4 saturate");
        for (int o = 0; o < W; o++) pop_expect(0, o, 16'hffff, "R4 saturate entries");
    endtask

    task automatic t_period();
        int d0, r0, d1, rn;
        d0 = done_n; r0 = rd_n;
        @(negedge clk);
        gap_cycles = PW'(5);
        scrub_en = 1'b1;
        wait (done_n == d0 + 1);
        d1 = done_cyc;
        wait (done_n == d0 + 2);
        @(negedge clk);
        scrub_en = 1'b0;
        chk(rd_cyc[r0 + TOT] - d1 == 6, "R8 next pass after gap+1 cycles", rd_cyc[r0 + TOT] - d1, 6);
        rn = rd_n;
        repeat (20) @(negedge clk);
        chk(rd_n == rn, "R8 stops when disabled", rd_n - rn, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_clean_pass();
        t_single_error();
        t_multi_error();
        t_persistent();
        t_overflow();
        t_saturate();
        t_period();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule